// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass

This block carries single urgent words between two independently clocked ports, outside the main FIFO path. The A side can post one word for the B side, and the B side can post one word for the A side. Each direction has one word of storage and an active-low full flag. The flag drops on the writer's clock edge that stores the word. It returns high once the reader has taken the word and that event has crossed back into the writer's clock domain.

Each port decodes a select-strobe operation from four inputs: a chip select, a direction bit, an enable and a mailbox select. With mailbox select high, the operation goes to a mailbox. With it low, the operation belongs to the FIFO, which sits outside this block. On the B side the output bus carries either the A-to-B mailbox word or the FIFO word supplied from outside.

Back-pressure works through the full flag and not through a ready signal. While a flag is low, every write to that mailbox is dropped and the stored word is kept. A reader gets no valid strobe. A mailbox read made before a word has arrived in the reader's domain leaves the flag as it is. Such a read returns whatever the register holds.

Top module: `mbx_bypass`

## Requirements
- R1: While either `rst_n` or `prst_n` is low, both `mbf1_n` and `mbf2_n` are high.
- R2: An A-side mailbox write (`a_cs_n`=0, `a_en`=1, `a_wr`=1, `a_mb`=1) with `mbf1_n` high stores `a_din` in the A-to-B register, and `mbf1_n` is low right after that `clk_a` edge.
- R3: An A-side mailbox write while `mbf1_n` is low is ignored, and the stored word is unchanged.
- R4: A B-side mailbox read (`b_cs_n`=0, `b_en`=1, `b_rd`=1, `b_mb`=1) returns the stored A-to-B word on `b_dout`. Once the word has reached the B domain, such a read makes `mbf1_n` go high within 8 `clk_a` cycles.
- R5: A B-side mailbox write (`b_cs_n`=0, `b_en`=1, `b_rd`=0, `b_mb`=1) with `mbf2_n` high stores `b_din` and drives `mbf2_n` low. An A-side mailbox read (`a_wr`=0, `a_mb`=1) returns that word on `a_dout` and makes `mbf2_n` go high within 8 `clk_b` cycles.
- R6: A B-side mailbox write while `mbf2_n` is low is ignored, and the stored word is unchanged.
- R7: `b_dout` is the A-to-B word when `b_cs_n`=0, `b_rd`=1 and `b_mb`=1. It is `fifo_rdata` when `b_cs_n`=0, `b_rd`=1 and `b_mb`=0, and zero otherwise. `a_dout` is the B-to-A word when `a_cs_n`=0 and `a_wr`=0, and zero otherwise.
- R8: A mailbox write with its enable low or its chip select high has no effect on the flag or on the stored word.
- R9: A mailbox read whose word has not yet crossed into the reader's domain, or whose mailbox is empty, leaves the flags unchanged. A flag never falls without an accepted write.
- R10: A partial reset sets both flags high and keeps the stored words, which later reads still return.
- R11: FIFO-path operations (mailbox select low) on either side change no mailbox flag or word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | A-side clock |
| clk_b | input | 1 | B-side clock, asynchronous to clk_a |
| rst_n | input | 1 | Full reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| a_cs_n | input | 1 | A-side chip select, active low |
| a_wr | input | 1 | A-side direction: 1 write, 0 read |
| a_en | input | 1 | A-side operation enable |
| a_mb | input | 1 | A-side mailbox select |
| a_din | input | W | A-side write data |
| a_dout | output | W | A-side read data (B-to-A word) |
| mbf1_n | output | 1 | A-to-B mailbox full, active low |
| b_cs_n | input | 1 | B-side chip select, active low |
| b_rd | input | 1 | B-side direction: 1 read, 0 write |
| b_en | input | 1 | B-side operation enable |
| b_mb | input | 1 | B-side mailbox select |
| b_din | input | W | B-side write data |
| fifo_rdata | input | W | FIFO word routed to b_dout when mailbox select is low |
| b_dout | output | W | B-side read data |
| mbf2_n | output | 1 | B-to-A mailbox full, active low |

## Verification
The hazardous overlap is a word written on the A side in the same stretch of cycles as a B-side mailbox read. In that case the read lands before the write has crossed the synchronizer. The bench provokes this by issuing the B read on the first `clk_b` edge after the A write. It judges the result by requiring `mbf1_n` to stay low for several `clk_a` cycles. A later read must then return the word and release the flag. Random rounds also stack a second write onto a full mailbox and put a FIFO read in between, with the expected words held by the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_FIFO_WR,
    OP_FIFO_RD,
    OP_MB_WR,
    OP_MB_RD
  } port_op_e;

  // Turn the strobe inputs of one port into the operation it requests.
  function automatic port_op_e decode_op(logic sel_n, logic en, logic is_wr, logic mb);
    port_op_e op;
    if (sel_n || !en) op = OP_NONE;
    else if (mb)      op = is_wr ? OP_MB_WR : OP_MB_RD;
    else              op = is_wr ? OP_FIFO_WR : OP_FIFO_RD;
    return op;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rd_req,
  output logic [W-1:0] rdata,
  output logic         full_w
);
  logic         wtog, rtog;
  logic         wtog_in_r, rtog_in_w;
  logic         avail_r;
  logic [W-1:0] word_q;

  // Writer domain: full while its own toggle differs from the returned read toggle.
  assign full_w  = wtog ^ rtog_in_w;
  // Reader domain: a word is present while the arrived write toggle differs.
  assign avail_r = wtog_in_r ^ rtog;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n)                 wtog <= 1'b0;
    else if (wr_req && !full_w) wtog <= ~wtog;

  // Storage is never cleared; a reset only clears the handshake.
  always_ff @(posedge wclk)
    if (wr_req && !full_w) word_q <= wdata;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n)                  rtog <= 1'b0;
    else if (rd_req && avail_r)  rtog <= ~rtog;

  mbx_sync #(.STAGES(STAGES)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_in_r));
  mbx_sync #(.STAGES(STAGES)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_in_w));

  assign rdata = word_q;
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         prst_n,
  input  logic         a_cs_n,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mb,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         mbf1_n,
  input  logic         b_cs_n,
  input  logic         b_rd,
  input  logic         b_en,
  input  logic         b_mb,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] fifo_rdata,
  output logic [W-1:0] b_dout,
  output logic         mbf2_n
);
  logic         rst_any_n;
  port_op_e     op_a, op_b;
  logic         full1, full2;
  logic [W-1:0] mail1_q, mail2_q;
  logic         a_oe, b_oe;

  assign rst_any_n = rst_n & prst_n;
  assign op_a = decode_op(a_cs_n, a_en, a_wr, a_mb);
  assign op_b = decode_op(b_cs_n, b_en, ~b_rd, b_mb);

  mbx_slot #(.W(W), .STAGES(STAGES)) u_a2b (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_any_n),
    .wr_req(op_a == OP_MB_WR), .wdata(a_din),
    .rd_req(op_b == OP_MB_RD), .rdata(mail1_q), .full_w(full1)
  );

  mbx_slot #(.W(W), .STAGES(STAGES)) u_b2a (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_any_n),
    .wr_req(op_b == OP_MB_WR), .wdata(b_din),
    .rd_req(op_a == OP_MB_RD), .rdata(mail2_q), .full_w(full2)
  );

  assign mbf1_n = ~full1;
  assign mbf2_n = ~full2;

  assign a_oe = ~a_cs_n & ~a_wr;
  assign b_oe = ~b_cs_n & b_rd;

  always_comb begin
    a_dout = '0;
    if (a_oe) a_dout = mail2_q;
    b_dout = '0;
    if (b_oe) b_dout = b_mb ? mail1_q : fifo_rdata;
  end
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_any_n,
  input logic         a_cs_n,
  input logic         a_wr,
  input logic         a_en,
  input logic         a_mb,
  input logic [W-1:0] a_din,
  input logic         b_cs_n,
  input logic         b_rd,
  input logic         b_en,
  input logic         b_mb,
  input logic [W-1:0] b_din,
  input logic         mbf1_n,
  input logic         mbf2_n,
  input logic [W-1:0] mail1_q,
  input logic [W-1:0] mail2_q
);
  logic wr1_try, wr2_try;
  assign wr1_try = !a_cs_n && a_en && a_wr && a_mb;
  assign wr2_try = !b_cs_n && b_en && !b_rd && b_mb;

  always @(posedge clk_a)
    if (!rst_any_n) assert_flags_reset_R1: assert (mbf1_n && mbf2_n);

  assert_mbf1_falls_R2: assert property (@(posedge clk_a) disable iff (!rst_any_n)
    (wr1_try && mbf1_n) |=> !mbf1_n);
  assert_mail1_load_R2: assert property (@(posedge clk_a) disable iff (!rst_any_n)
    (wr1_try && mbf1_n) |=> (mail1_q == $past(a_din)));
  assert_mail1_hold_R3: assert property (@(posedge clk_a) disable iff (!rst_any_n)
    (wr1_try && !mbf1_n) |=> (mail1_q == $past(mail1_q)));
  assert_mbf1_no_fall_R9: assert property (@(posedge clk_a) disable iff (!rst_any_n)
    (mbf1_n && !wr1_try) |=> mbf1_n);

  assert_mbf2_falls_R5: assert property (@(posedge clk_b) disable iff (!rst_any_n)
    (wr2_try && mbf2_n) |=> !mbf2_n);
  assert_mail2_load_R5: assert property (@(posedge clk_b) disable iff (!rst_any_n)
    (wr2_try && mbf2_n) |=> (mail2_q == $past(b_din)));
  assert_mail2_hold_R6: assert property (@(posedge clk_b) disable iff (!rst_any_n)
    (wr2_try && !mbf2_n) |=> (mail2_q == $past(mail2_q)));
  assert_mbf2_no_fall_R9: assert property (@(posedge clk_b) disable iff (!rst_any_n)
    (mbf2_n && !wr2_try) |=> mbf2_n);
endmodule

bind mbx_bypass mbx_bypass_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_any_n(rst_any_n),
  .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb), .a_din(a_din),
  .b_cs_n(b_cs_n), .b_rd(b_rd), .b_en(b_en), .b_mb(b_mb), .b_din(b_din),
  .mbf1_n(mbf1_n), .mbf2_n(mbf2_n), .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/sim_mbx_bypass.sv
module sim_mbx_bypass;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0;
  logic rst_n = 0, prst_n = 1;
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic b_cs_n = 1, b_rd = 1, b_en = 0, b_mb = 0;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_rdata = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_n, mbf2_n;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_a = ~clk_a;
  initial begin #3; forever #4 clk_b = ~clk_b; end

  mbx_bypass #(.W(W)) u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .prst_n(prst_n),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb),
    .a_din(a_din), .a_dout(a_dout), .mbf1_n(mbf1_n),
    .b_cs_n(b_cs_n), .b_rd(b_rd), .b_en(b_en), .b_mb(b_mb),
    .b_din(b_din), .fifo_rdata(fifo_rdata), .b_dout(b_dout), .mbf2_n(mbf2_n)
  );

  function automatic logic [W-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  // Expected B bus from the R7 rule.
  function automatic logic [W-1:0] exp_b(logic cs_n, logic rd, logic mb,
                                         logic [W-1:0] mail, logic [W-1:0] fifo);
    if (cs_n || !rd) return '0;
    return mb ? mail : fifo;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_idle(); a_cs_n = 1; a_en = 0; a_mb = 0; a_wr = 0; endtask
  task automatic b_idle(); b_cs_n = 1; b_en = 0; b_mb = 0; b_rd = 1; endtask

  task automatic a_op(logic wr, logic mb, logic en, logic [W-1:0] d, output logic [W-1:0] got);
    @(negedge clk_a);
    a_cs_n = 0; a_en = en; a_wr = wr; a_mb = mb; a_din = d;
    #1 got = a_dout;
    @(negedge clk_a);
    a_idle();
  endtask

  task automatic b_op(logic rd, logic mb, logic en, logic [W-1:0] d, output logic [W-1:0] got);
    @(negedge clk_b);
    b_cs_n = 0; b_en = en; b_rd = rd; b_mb = mb; b_din = d;
    #1 got = b_dout;
    @(negedge clk_b);
    b_idle();
  endtask

  task automatic wait_flag(bit which, string req);
    bit seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (which == 0) @(negedge clk_a); else @(negedge clk_b);
      if ((which == 0 ? mbf1_n : mbf2_n) && !seen) seen = 1;
    end
    check(seen, req, {35'd0, seen}, 1);
  endtask

  logic [W-1:0] m1, m2, got, d2, f;

  initial begin
    void'($urandom(32'd20240611));
    // R1: flags high during and after full reset
    repeat (3) @(negedge clk_a);
    check(mbf1_n && mbf2_n, "R1 in reset", {34'd0, mbf1_n, mbf2_n}, 3);
    rst_n = 1;
    repeat (3) @(negedge clk_a);
    check(mbf1_n && mbf2_n, "R1 after reset", {34'd0, mbf1_n, mbf2_n}, 3);
    check(b_dout == '0 && a_dout == '0, "R7 idle buses zero", b_dout | a_dout, '0);

    // R8: disabled write ignored
    a_op(1, 1, 0, 36'h123456789, got);
    check(mbf1_n == 1, "R8 disabled write keeps flag", {35'd0, mbf1_n}, 1);

    // R2 + R9 overlap: B read right after A write, before the crossing
    m1 = 36'hA5A5_0F0F1;
    a_op(1, 1, 1, m1, got);
    check(mbf1_n == 0, "R2 flag low after write", {35'd0, mbf1_n}, 0);
    b_op(1, 1, 1, '0, got);
    repeat (6) @(negedge clk_a);
    check(mbf1_n == 0, "R9 early read leaves flag low", {35'd0, mbf1_n}, 0);
    b_op(1, 1, 1, '0, got);
    check(got == m1, "R4 mailbox read data", got, m1);
    wait_flag(0, "R4 flag released");
    // R9: empty read keeps flag high and returns stale word
    b_op(1, 1, 1, '0, got);
    check(got == m1, "R9 empty read stale data", got, m1);
    repeat (4) @(negedge clk_a);
    check(mbf1_n == 1, "R9 empty read keeps flag", {35'd0, mbf1_n}, 1);

    // R11: FIFO-path ops on both sides touch no mailbox
    a_op(1, 0, 1, 36'hFFFF_FFFF0, got);
    b_op(0, 0, 1, 36'h0DEAD_BEE0, got);
    check(mbf1_n && mbf2_n, "R11 FIFO ops keep flags", {34'd0, mbf1_n, mbf2_n}, 3);
    b_op(1, 1, 1, '0, got);
    check(got == m1, "R11 FIFO write kept mail1", got, m1);

    // R10: partial reset keeps the word, restores flags
    m2 = 36'h3C3C_1234_5;
    b_op(0, 1, 1, m2, got);
    check(mbf2_n == 0, "R5 flag low after B write", {35'd0, mbf2_n}, 0);
    @(negedge clk_a); prst_n = 0;
    @(negedge clk_a);
    check(mbf1_n && mbf2_n, "R10 flags high in partial reset", {34'd0, mbf1_n, mbf2_n}, 3);
    prst_n = 1;
    repeat (2) @(negedge clk_a);
    a_op(0, 1, 1, '0, got);
    check(got == m2, "R10 word kept after partial reset", got, m2);

    // Random rounds
    for (int it = 0; it < 40; it++) begin
      m1 = rnd();
      a_op(1, 1, 1, m1, got);
      check(mbf1_n == 0, "R2 random write", {35'd0, mbf1_n}, 0);
      if ($urandom() % 2 == 1) begin
        d2 = rnd();
        a_op(1, 1, 1, d2, got);
        check(mbf1_n == 0, "R3 second write flag", {35'd0, mbf1_n}, 0);
      end
      repeat (4) @(negedge clk_b);
      f = rnd();
      fifo_rdata = f;
      b_op(1, 0, 1, '0, got);
      check(got == exp_b(0, 1, 0, m1, f), "R7 FIFO word on B bus", got, f);
      b_op(1, 1, 1, '0, got);
      check(got == exp_b(0, 1, 1, m1, f), "R3/R4 mail1 word", got, m1);
      wait_flag(0, "R4 random release");

      m2 = rnd();
      b_op(0, 1, 1, m2, got);
      check(mbf2_n == 0, "R5 random write", {35'd0, mbf2_n}, 0);
      if ($urandom() % 2 == 1) begin
        d2 = rnd();
        b_op(0, 1, 1, d2, got);
        check(mbf2_n == 0, "R6 second write flag", {35'd0, mbf2_n}, 0);
      end
      repeat (4) @(negedge clk_a);
      a_op(0, 1, 1, '0, got);
      check(got == m2, "R6/R5 mail2 word", got, m2);
      wait_flag(1, "R5 random release");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule